// File: doc/BRIEF.md
# Opcode Escape-Prefix Tracker

This block watches an instruction byte stream, one byte per valid cycle, and classifies each instruction for the decode stage of an 8-bit processor core. Four byte values act as escapes: `CB` opens the bit-operation table, `ED` opens the extended table, and `DD` and `FD` make the HL-role operands of the next instruction use the index registers IX and IY. For each completed instruction the tracker emits a one-cycle descriptor. The descriptor gives the table the opcode came from and the opcode itself. It gives the register that takes the HL role and whether a signed displacement byte belongs to the instruction. It gives how many immediate bytes follow, and whether the H and L register fields should be steered to the halves of the index register.

After a descriptor the tracker consumes the operand bytes it announced, so that an operand value that looks like an escape is never read as one. It then starts the next instruction with no prefix. An index prefix that is overwritten by a later index prefix, or cancelled by `ED`, produces a one-cycle `prefix_ignored` pulse. Executing instructions, fetching memory and updating flags are left to other blocks.

Top module: `opcode_prefix_tracker`

## Requirements
- R1: While reset is held and in the first cycle after it, `desc_valid` and `prefix_ignored` are low. The first instruction after reset is unprefixed (`desc_index` = 0).
- R2: An unprefixed opcode byte produces `desc_valid` in the cycle after that byte. It comes with `desc_table` = 0 (main), `desc_index` = 0 (HL), the opcode on `desc_opcode`, and `desc_imm` equal to the instruction's immediate byte count: for example 00→0, 3E→1, 01→2, C3→2, D3→1.
- R3: After a descriptor, the next `desc_disp + desc_imm` valid bytes are operands. They produce neither a descriptor nor a `prefix_ignored` pulse, whatever their value.
- R4: After `DD` (or `FD`), an opcode that uses the (HL) memory operand reports `desc_index` = 1 (or 2) and `desc_disp` = 1. Its immediate count is unchanged, so `DD 36` reports one displacement and one immediate.
- R5: After an index prefix, an opcode that names H or L as a register but not (HL) reports `desc_remap` = 1, `desc_disp` = 0 and the index register (for example `DD 24`, `FD 2E`).
- R6: An index-prefixed opcode that names both H or L and (HL) (for example 66, 74) reports `desc_remap` = 0 and `desc_disp` = 1.
- R7: An index prefix before an opcode that uses none of H, L, HL or (HL) has no effect: `desc_index` = 0, `desc_disp` = 0, `desc_remap` = 0 and no pulse. This applies to 37, C3, EB (exchange DE with HL) and D9 (exchange register banks).
- R8: Index-prefixed opcodes that use HL as a 16-bit pair report the index register with `desc_disp` = 0. This covers the indirect jump E9 and the loads 21 (two immediates).
- R9: In a run of `DD`/`FD` bytes only the last is applied. Each overwritten prefix raises `prefix_ignored` for one cycle, in the cycle after the byte that replaced it.
- R10: `ED` after an index prefix raises `prefix_ignored` in the cycle after the `ED`, and the extended instruction reports `desc_index` = 0.
- R11: An `ED` plus a following byte produces `desc_table` = 2 with that byte as opcode. `desc_imm` = 2 when the opcode bits [7:6] = 01 and [2:0] = 011, else 0. A `CB`, `DD`, `ED` or `FD` after `ED` is consumed as such an opcode and sets no prefix.
- R12: An unprefixed `CB` followed by a byte produces `desc_table` = 1, `desc_index` = 0, `desc_disp` = 0, `desc_imm` = 0.
- R13: A sequence `DD`/`FD`, `CB`, displacement, opcode produces a single descriptor after the last byte. It reports `desc_table` = 3, the index register, `desc_disp` = 1 and `desc_imm` = 0, and the displacement byte is never taken as an escape.
- R14: After every descriptor and its operands, the next opcode is decoded as unprefixed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | A stream byte is present on `byte_in` |
| byte_in | input | 8 | Instruction stream byte |
| desc_valid | output | 1 | One-cycle descriptor strobe |
| desc_table | output | 2 | 0 main, 1 bit-ops, 2 extended, 3 indexed bit-ops |
| desc_index | output | 2 | HL-role register: 0 HL, 1 IX, 2 IY |
| desc_opcode | output | 8 | Opcode byte that completed the instruction |
| desc_disp | output | 1 | Instruction carries a displacement byte |
| desc_imm | output | 2 | Number of immediate bytes |
| desc_remap | output | 1 | H/L register fields map to index halves |
| prefix_ignored | output | 1 | One-cycle pulse for a discarded index prefix |

## Verification
The bench feeds operand bytes equal to `DD`, `FD` and `CB` right after instructions that carry operands. A tracker that miscounts operands would then report a false descriptor, a pulse, or a prefixed next instruction. It places `DD 66` and `FD 74` next to `DD 24` and `FD 2E`. Getting the (HL)-over-H/L priority wrong would show up as `desc_remap` set together with a displacement. Prefix chains and `FD ED` check the pulse count and the final register: a design that keeps the first prefix, or lets an index prefix pass through `ED`, reports the wrong `desc_index`. `DD CB DD 06` checks that the displacement sits before the final opcode and is not read as a new prefix.

// File: rtl/opcode_prefix_pkg.sv
// Shared encodings for the escape-prefix tracker.
// Assumes 8-bit opcode bytes; escape values are fixed by the instruction set.
package opcode_prefix_pkg;

    localparam int OPC_W  = 8;
    localparam int CNT_W  = 2;

    localparam logic [OPC_W-1:0] ESC_BIT = 8'hCB;
    localparam logic [OPC_W-1:0] ESC_IX  = 8'hDD;
    localparam logic [OPC_W-1:0] ESC_EXT = 8'hED;
    localparam logic [OPC_W-1:0] ESC_IY  = 8'hFD;

    typedef enum logic [1:0] {
        IDX_HL = 2'd0,
        IDX_IX = 2'd1,
        IDX_IY = 2'd2
    } idx_e;

    typedef enum logic [1:0] {
        TBL_MAIN   = 2'd0,
        TBL_BIT    = 2'd1,
        TBL_EXT    = 2'd2,
        TBL_IDXBIT = 2'd3
    } tbl_e;

    typedef enum logic [2:0] {
        ST_OPC   = 3'd0,
        ST_BIT   = 3'd1,
        ST_EXT   = 3'd2,
        ST_XDISP = 3'd3,
        ST_XOP   = 3'd4,
        ST_SKIP  = 3'd5
    } st_e;

    typedef struct packed {
        tbl_e             tbl;
        idx_e             idx;
        logic             disp;
        logic [CNT_W-1:0] imm;
        logic             remap;
        logic [OPC_W-1:0] opc;
    } desc_t;

endpackage

// File: rtl/pfx_main_decode.sv
// Classifies a main-table opcode: immediate byte count, (HL) memory use,
// 16-bit HL pair use, and H/L register-field use.
// Assumes the byte is not an escape value; results for escapes are unused.
module pfx_main_decode
    import opcode_prefix_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output logic [CNT_W-1:0] imm,
    output logic             mem_ref,
    output logic             hl_pair,
    output logic             hl_half
);
    logic [1:0] fx;
    logic [2:0] fy;
    logic [2:0] fz;
    logic [1:0] fp;
    logic       fq;
    logic       y_half;
    logic       z_half;

    assign fx = opc[7:6];
    assign fy = opc[5:3];
    assign fz = opc[2:0];
    assign fp = opc[5:4];
    assign fq = opc[3];
    assign y_half = (fy == 3'd4) || (fy == 3'd5);
    assign z_half = (fz == 3'd4) || (fz == 3'd5);

    // Immediate operand count from the opcode's quadrant and column.
    always_comb begin
        imm = '0;
        unique case (fx)
            2'd0: begin
                case (fz)
                    3'd0: imm = (fy >= 3'd2) ? 2'd1 : 2'd0;
                    3'd1: imm = fq ? 2'd0 : 2'd2;
                    3'd2: imm = (fy >= 3'd4) ? 2'd2 : 2'd0;
                    3'd6: imm = 2'd1;
                    default: imm = 2'd0;
                endcase
            end
            2'd3: begin
                case (fz)
                    3'd2, 3'd4: imm = 2'd2;
                    3'd3: begin
                        if (fy == 3'd0)                        imm = 2'd2;
                        else if (fy == 3'd2 || fy == 3'd3)     imm = 2'd1;
                        else                                   imm = 2'd0;
                    end
                    3'd5: imm = (fq && fp == 2'd0) ? 2'd2 : 2'd0;
                    3'd6: imm = 2'd1;
                    default: imm = 2'd0;
                endcase
            end
            default: imm = 2'd0;
        endcase
    end

    // Memory operand through HL: inc/dec/load-immediate, register loads, ALU.
    always_comb begin
        mem_ref = 1'b0;
        if (fx == 2'd0)      mem_ref = (opc == 8'h34) || (opc == 8'h35) || (opc == 8'h36);
        else if (fx == 2'd1) mem_ref = (fy == 3'd6) != (fz == 3'd6);
        else if (fx == 2'd2) mem_ref = (fz == 3'd6);
    end

    // H or L named as an 8-bit register field.
    always_comb begin
        hl_half = 1'b0;
        if (fx == 2'd0)      hl_half = y_half && (fz == 3'd4 || fz == 3'd5 || fz == 3'd6);
        else if (fx == 2'd1) hl_half = (opc != 8'h76) && (y_half || z_half);
        else if (fx == 2'd2) hl_half = z_half;
    end

    // HL used as a 16-bit pair (loads, add, inc/dec, stack, jump, SP load).
    always_comb begin
        hl_pair = 1'b0;
        if (fx == 2'd0)
            hl_pair = ((fz == 3'd1) && (fq || fp == 2'd2)) ||
                      ((fz == 3'd2 || fz == 3'd3) && fp == 2'd2);
        else if (fx == 2'd3)
            hl_pair = (opc == 8'hE1) || (opc == 8'hE3) || (opc == 8'hE5) ||
                      (opc == 8'hE9) || (opc == 8'hF9);
    end

endmodule

// File: rtl/pfx_ext_decode.sv
// Immediate count for extended-table opcodes: only the 16-bit absolute
// load/store column carries a two-byte address.
// Assumes unused extended codes act as two-byte no-operations.
module pfx_ext_decode
    import opcode_prefix_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output logic [CNT_W-1:0] imm
);
    // Address operand present for quadrant 1, column 3.
    always_comb begin
        imm = (opc[7:6] == 2'd1 && opc[2:0] == 3'd3) ? 2'd2 : 2'd0;
    end
endmodule

// File: rtl/pfx_sequencer.sv
// Prefix state machine: holds the pending index prefix, walks the escape
// sequences, registers one descriptor per instruction and skips operands.
// Assumes decode inputs are combinational functions of byte_in.
module pfx_sequencer
    import opcode_prefix_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    input  logic [OPC_W-1:0] byte_in,
    input  logic [CNT_W-1:0] main_imm,
    input  logic             main_mem,
    input  logic             main_pair,
    input  logic             main_half,
    input  logic [CNT_W-1:0] ext_imm,
    output desc_t            desc,
    output logic             desc_fire,
    output logic             ign_pulse
);
    st_e              state;
    idx_e             idx_q;
    logic [CNT_W-1:0] skip_q;

    logic             effect;
    logic             m_disp;
    desc_t            main_desc;
    logic [CNT_W-1:0] main_skip;
    logic             is_idx_esc;

    // Descriptor for a main-table opcode under the pending prefix.
    always_comb begin
        is_idx_esc      = (byte_in == ESC_IX) || (byte_in == ESC_IY);
        effect          = (idx_q != IDX_HL) && (main_mem || main_pair || main_half);
        m_disp          = effect && main_mem;
        main_desc.tbl   = TBL_MAIN;
        main_desc.idx   = effect ? idx_q : IDX_HL;
        main_desc.disp  = m_disp;
        main_desc.imm   = main_imm;
        main_desc.remap = effect && main_half && !main_mem;
        main_desc.opc   = byte_in;
        main_skip       = main_imm + {{(CNT_W-1){1'b0}}, m_disp};
    end

    // Sequence state, pending prefix and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_OPC;
            idx_q     <= IDX_HL;
            skip_q    <= '0;
            desc      <= '0;
            desc_fire <= 1'b0;
            ign_pulse <= 1'b0;
        end else begin
            desc_fire <= 1'b0;
            ign_pulse <= 1'b0;
            if (byte_valid) begin
                unique case (state)
                    ST_OPC: begin
                        if (is_idx_esc) begin
                            ign_pulse <= (idx_q != IDX_HL);
                            idx_q     <= (byte_in == ESC_IX) ? IDX_IX : IDX_IY;
                        end else if (byte_in == ESC_EXT) begin
                            ign_pulse <= (idx_q != IDX_HL);
                            idx_q     <= IDX_HL;
                            state     <= ST_EXT;
                        end else if (byte_in == ESC_BIT) begin
                            state <= (idx_q == IDX_HL) ? ST_BIT : ST_XDISP;
                        end else begin
                            desc      <= main_desc;
                            desc_fire <= 1'b1;
                            idx_q     <= IDX_HL;
                            if (main_skip != '0) begin
                                skip_q <= main_skip;
                                state  <= ST_SKIP;
                            end
                        end
                    end
                    ST_BIT: begin
                        desc       <= '{tbl: TBL_BIT, idx: IDX_HL, disp: 1'b0,
                                        imm: '0, remap: 1'b0, opc: byte_in};
                        desc_fire  <= 1'b1;
                        state      <= ST_OPC;
                    end
                    ST_EXT: begin
                        desc      <= '{tbl: TBL_EXT, idx: IDX_HL, disp: 1'b0,
                                       imm: ext_imm, remap: 1'b0, opc: byte_in};
                        desc_fire <= 1'b1;
                        if (ext_imm != '0) begin
                            skip_q <= ext_imm;
                            state  <= ST_SKIP;
                        end else begin
                            state  <= ST_OPC;
                        end
                    end
                    ST_XDISP: begin
                        state <= ST_XOP;
                    end
                    ST_XOP: begin
                        desc      <= '{tbl: TBL_IDXBIT, idx: idx_q, disp: 1'b1,
                                       imm: '0, remap: 1'b0, opc: byte_in};
                        desc_fire <= 1'b1;
                        idx_q     <= IDX_HL;
                        state     <= ST_OPC;
                    end
                    ST_SKIP: begin
                        skip_q <= skip_q - 1'b1;
                        if (skip_q == 2'd1) state <= ST_OPC;
                    end
                    default: state <= ST_OPC;
                endcase
            end
        end
    end

    AST_FIRE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        desc_fire |-> $past(byte_valid)); // R3
    AST_DISP_ONLY_INDEXED: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_fire && desc.disp) |-> (desc.idx != IDX_HL)); // R4
    AST_REMAP_NOT_WITH_DISP: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_fire && desc.remap) |-> !desc.disp); // R6
    AST_IGNORE_AFTER_ESCAPE: assert property (@(posedge clk) disable iff (!rst_n)
        ign_pulse |-> ($past(byte_valid) && ($past(byte_in) == ESC_IX ||
                       $past(byte_in) == ESC_IY || $past(byte_in) == ESC_EXT))); // R9
    AST_EXT_UNINDEXED: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_fire && desc.tbl == TBL_EXT) |-> (desc.idx == IDX_HL)); // R10
    AST_IDXBIT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_fire && desc.tbl == TBL_IDXBIT) |-> (desc.disp && desc.imm == '0 &&
                                                   desc.idx != IDX_HL)); // R13
    AST_NO_FIRE_AND_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(desc_fire && ign_pulse)); // R9

endmodule

// File: rtl/opcode_prefix_tracker.sv
// Top level: byte-serial escape-prefix tracker. Decodes each byte with the
// main and extended classifiers and lets the sequencer build descriptors.
// Assumes one stream byte per cycle when byte_valid is high.
module opcode_prefix_tracker
    import opcode_prefix_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_valid,
    input  logic [7:0] byte_in,
    output logic       desc_valid,
    output logic [1:0] desc_table,
    output logic [1:0] desc_index,
    output logic [7:0] desc_opcode,
    output logic       desc_disp,
    output logic [1:0] desc_imm,
    output logic       desc_remap,
    output logic       prefix_ignored
);
    logic [CNT_W-1:0] main_imm;
    logic             main_mem;
    logic             main_pair;
    logic             main_half;
    logic [CNT_W-1:0] ext_imm;
    desc_t            desc;

    pfx_main_decode u_main (
        .opc     (byte_in),
        .imm     (main_imm),
        .mem_ref (main_mem),
        .hl_pair (main_pair),
        .hl_half (main_half)
    );

    pfx_ext_decode u_ext (
        .opc (byte_in),
        .imm (ext_imm)
    );

    pfx_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .main_imm   (main_imm),
        .main_mem   (main_mem),
        .main_pair  (main_pair),
        .main_half  (main_half),
        .ext_imm    (ext_imm),
        .desc       (desc),
        .desc_fire  (desc_valid),
        .ign_pulse  (prefix_ignored)
    );

    // Unpack the registered descriptor onto plain ports.
    always_comb begin
        desc_table  = desc.tbl;
        desc_index  = desc.idx;
        desc_opcode = desc.opc;
        desc_disp   = desc.disp;
        desc_imm    = desc.imm;
        desc_remap  = desc.remap;
    end

endmodule

// File: tb/opcode_prefix_tracker_test.sv
`timescale 1ns/1ps
module opcode_prefix_tracker_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       desc_valid;
    logic [1:0] desc_table;
    logic [1:0] desc_index;
    logic [7:0] desc_opcode;
    logic       desc_disp;
    logic [1:0] desc_imm;
    logic       desc_remap;
    logic       prefix_ignored;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic       s_fire, s_ign, s_disp, s_remap;
    logic [1:0] s_tbl, s_idx, s_imm;
    logic [7:0] s_opc;

    always #2 clk = ~clk;

    opcode_prefix_tracker uut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_in(byte_in),
        .desc_valid(desc_valid), .desc_table(desc_table), .desc_index(desc_index),
        .desc_opcode(desc_opcode), .desc_disp(desc_disp), .desc_imm(desc_imm),
        .desc_remap(desc_remap), .prefix_ignored(prefix_ignored)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic capture();
        s_fire = desc_valid; s_ign = prefix_ignored; s_tbl = desc_table;
        s_idx = desc_index; s_opc = desc_opcode; s_disp = desc_disp;
        s_imm = desc_imm; s_remap = desc_remap;
    endtask

    // Present one byte; outputs for it are sampled just after the edge.
    task automatic feed(input logic [7:0] b);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_in    = b;
        @(posedge clk);
        #1;
        byte_valid = 1'b0;
        capture();
    endtask

    task automatic quiet(input string req, input logic [7:0] b);
        feed(b);
        chk(req, "desc_valid", s_fire, 0);
        chk(req, "prefix_ignored", s_ign, 0);
    endtask

    task automatic expect_desc(input string req, input logic [7:0] b, input int tbl,
                               input int idx, input int disp, input int imm, input int remap);
        feed(b);
        chk(req, "desc_valid", s_fire, 1);
        chk(req, "table", s_tbl, tbl);
        chk(req, "index", s_idx, idx);
        chk(req, "opcode", s_opc, b);
        chk(req, "disp", s_disp, disp);
        chk(req, "imm", s_imm, imm);
        chk(req, "remap", s_remap, remap);
    endtask

    task automatic t_reset();
        @(negedge clk);
        byte_valid = 1'b1; byte_in = 8'hDD;
        repeat (2) @(posedge clk);
        #1; capture();
        chk("R1", "desc_valid in reset", s_fire, 0);
        chk("R1", "prefix_ignored in reset", s_ign, 0);
        @(negedge clk); byte_valid = 1'b0; rst_n = 1'b1;
        @(posedge clk); #1; capture();
        chk("R1", "desc_valid after reset", s_fire, 0);
        chk("R1", "prefix_ignored after reset", s_ign, 0);
        expect_desc("R1", 8'h24, 0, 0, 0, 0, 0);
    endtask

    task automatic t_plain();
        expect_desc("R2", 8'h00, 0, 0, 0, 0, 0);
        expect_desc("R2", 8'h3E, 0, 0, 0, 1, 0);
        quiet("R3", 8'hDD);
        expect_desc("R2", 8'h01, 0, 0, 0, 2, 0);
        quiet("R3", 8'hFD);
        quiet("R3", 8'hCB);
        expect_desc("R14", 8'h24, 0, 0, 0, 0, 0);
        expect_desc("R2", 8'hC3, 0, 0, 0, 2, 0);
        quiet("R3", 8'hED); quiet("R3", 8'hDD);
        expect_desc("R2", 8'hD3, 0, 0, 0, 1, 0);
        quiet("R3", 8'hFD);
    endtask

    task automatic t_mem();
        quiet("R4", 8'hDD);
        expect_desc("R4", 8'h7E, 0, 1, 1, 0, 0);
        quiet("R3", 8'hFD);
        expect_desc("R14", 8'h7E, 0, 0, 0, 0, 0);
        quiet("R4", 8'hFD);
        expect_desc("R4", 8'h36, 0, 2, 1, 1, 0);
        quiet("R3", 8'hDD); quiet("R3", 8'hCB);
        expect_desc("R14", 8'h00, 0, 0, 0, 0, 0);
        quiet("R4", 8'hDD);
        expect_desc("R4", 8'hB6, 0, 1, 1, 0, 0);
        quiet("R3", 8'h05);
    endtask

    task automatic t_half();
        quiet("R5", 8'hDD);
        expect_desc("R5", 8'h24, 0, 1, 0, 0, 1);
        quiet("R5", 8'hFD);
        expect_desc("R5", 8'h2E, 0, 2, 0, 1, 1);
        quiet("R3", 8'hED);
        quiet("R5", 8'hDD);
        expect_desc("R5", 8'h7C, 0, 1, 0, 0, 1);
    endtask

    task automatic t_both();
        quiet("R6", 8'hDD);
        expect_desc("R6", 8'h66, 0, 1, 1, 0, 0);
        quiet("R3", 8'h10);
        quiet("R6", 8'hFD);
        expect_desc("R6", 8'h74, 0, 2, 1, 0, 0);
        quiet("R3", 8'hF0);
    endtask

    task automatic t_noeffect();
        quiet("R7", 8'hDD);
        expect_desc("R7", 8'h37, 0, 0, 0, 0, 0);
        quiet("R7", 8'hFD);
        expect_desc("R7", 8'hC3, 0, 0, 0, 2, 0);
        quiet("R3", 8'h00); quiet("R3", 8'h80);
        quiet("R7", 8'hDD);
        expect_desc("R7", 8'hEB, 0, 0, 0, 0, 0);
        quiet("R7", 8'hFD);
        expect_desc("R7", 8'hD9, 0, 0, 0, 0, 0);
    endtask

    task automatic t_pair();
        quiet("R8", 8'hDD);
        expect_desc("R8", 8'hE9, 0, 1, 0, 0, 0);
        quiet("R8", 8'hFD);
        expect_desc("R8", 8'h21, 0, 2, 0, 2, 0);
        quiet("R3", 8'h34); quiet("R3", 8'h12);
    endtask

    task automatic t_chain();
        int pulses = 0;
        feed(8'hDD); pulses += int'(s_ign);
        chk("R9", "first prefix pulse", s_ign, 0);
        feed(8'hFD); pulses += int'(s_ign);
        chk("R9", "second prefix pulse", s_ign, 1);
        feed(8'hDD); pulses += int'(s_ign);
        feed(8'hFD); pulses += int'(s_ign);
        chk("R9", "pulse count", pulses, 3);
        expect_desc("R9", 8'h7E, 0, 2, 1, 0, 0);
        quiet("R3", 8'hDD);
    endtask

    task automatic t_edcancel();
        quiet("R10", 8'hFD);
        feed(8'hED);
        chk("R10", "pulse on ED", s_ign, 1);
        chk("R10", "no descriptor on ED", s_fire, 0);
        expect_desc("R10", 8'h43, 2, 0, 0, 2, 0);
        quiet("R3", 8'hFD); quiet("R3", 8'hDD);
        quiet("R11", 8'hED);
        expect_desc("R11", 8'h44, 2, 0, 0, 0, 0);
    endtask

    task automatic t_ednop();
        quiet("R11", 8'hED);
        expect_desc("R11", 8'hDD, 2, 0, 0, 0, 0);
        expect_desc("R11", 8'h24, 0, 0, 0, 0, 0);
        quiet("R11", 8'hED);
        expect_desc("R11", 8'hCB, 2, 0, 0, 0, 0);
        expect_desc("R11", 8'h00, 0, 0, 0, 0, 0);
    endtask

    task automatic t_bit();
        quiet("R12", 8'hCB);
        expect_desc("R12", 8'h30, 1, 0, 0, 0, 0);
        expect_desc("R12", 8'h3E, 0, 0, 0, 1, 0);
        quiet("R3", 8'hCB);
    endtask

    task automatic t_idxbit();
        quiet("R13", 8'hDD);
        quiet("R13", 8'hCB);
        quiet("R13", 8'hDD);
        expect_desc("R13", 8'h06, 3, 1, 1, 0, 0);
        quiet("R13", 8'hFD);
        quiet("R13", 8'hCB);
        quiet("R13", 8'h05);
        expect_desc("R13", 8'hC6, 3, 2, 1, 0, 0);
        expect_desc("R14", 8'h24, 0, 0, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_plain();
        t_mem();
        t_half();
        t_both();
        t_noeffect();
        t_pair();
        t_chain();
        t_edcancel();
        t_ednop();
        t_bit();
        t_idxbit();
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule